// File: doc/BRIEF.md
# Random-Access Scan Update Controller

This block applies a new test vector to an array of individually addressable storage cells by rewriting only the cells whose next value differs from the response they just captured. The caller supplies a count `d` and a list of `d` entries, each a cell address and a new bit value. For every entry the controller shifts the address onto a one-bit serial address line, most significant bit first, over `T = ceil(log2 NCELLS)` cycles. It then spends a single cycle writing the new value into the cell that the assembled address selects.

A vector update therefore costs `d*(1+T)` cycles. A full scan shift would cost `ceil(NCELLS/m)` cycles per vector over `m` chains. The cell array sits inside the block as a small parameterised register file. While the block is idle, a parallel capture port loads the array with a circuit response.

The sequencer has four states. IDLE waits for `start`. SHIFT sends one address bit per cycle. WRITE updates the addressed cell. FINISH raises `done` for one cycle.

The transitions are:
- IDLE→SHIFT on `start` with a nonzero count.
- IDLE→FINISH on `start` with a zero count.
- SHIFT→SHIFT while address bits remain.
- SHIFT→WRITE after the last address bit.
- WRITE→SHIFT when further entries remain.
- WRITE→FINISH after the last entry.
- FINISH→IDLE unconditionally.

Top module: `ras_update_ctrl`

## Requirements
- R1: After reset, `cells` is all zero, and `busy` and `done` are both 0.
- R2: When `cap_en` is 1 in a cycle where the block is neither busy nor done, `cells` takes `cap_data` at the next edge. `cap_en` has no effect while `busy` or `done` is 1.
- R3: For each entry, `busy` is 1 for T shift cycles followed by one write cycle, so one run holds `busy` high for exactly `d*(1+T)` consecutive cycles. During shift cycle k (k = 0..T-1) of an entry, `addr_sbit` equals address bit T-1-k, so the most significant bit comes first.
- R4: The write cycle of an entry sets cell `list_addr` to `list_val`, and leaves every other cell unchanged. Cells change at most one bit per cycle during a run.
- R5: An entry whose address is NCELLS or larger writes no cell.
- R6: `done` is a single-cycle pulse in the cycle right after the last write. With `d` = 0, `done` rises in the cycle after `start` is accepted, and `busy` never rises.
- R7: `start` is accepted only when `busy` and `done` are both 0. It is ignored at other times.
- R8: `list_idx` presents entry indices 0 to d-1 in order. When two entries name the same cell, the later entry's value remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin applying a list of updates |
| upd_count | input | CW | Number of entries d, sampled with `start` |
| list_idx | output | CW | Index of the entry currently requested |
| list_addr | input | AW | Address of entry `list_idx` |
| list_val | input | 1 | New bit value of entry `list_idx` |
| cap_en | input | 1 | Parallel capture strobe (idle only) |
| cap_data | input | NCELLS | Response to capture into the array |
| cells | output | NCELLS | Current contents of the cell array |
| addr_sbit | output | 1 | Serial address line, MSB first |
| busy | output | 1 | High during SHIFT and WRITE |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bound checker watches every cycle for four properties:
- `done` is a lone pulse that follows the fall of `busy`.
- `cells` keeps its value in every cycle that is neither a write nor an accepted capture.
- No more than one cell changes per cycle during a run.
- The number of busy cycles in each run equals `d*(1+T)` for the count latched at `start`.

Only the bench scenarios can show the following:
- The serial address line carries the right bits, MSB first.
- The right cell receives the right value, including when entries are out of range or repeat an address.
- A refused `start` or capture leaves the array as it was.

// File: rtl/ras_pkg.sv
package ras_pkg;
    typedef enum logic [1:0] {
        RS_IDLE   = 2'd0,
        RS_SHIFT  = 2'd1,
        RS_WRITE  = 2'd2,
        RS_FINISH = 2'd3
    } ras_state_e;
endpackage

// File: rtl/ras_seq.sv
module ras_seq
    import ras_pkg::*;
#(
    parameter int AW = 4,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] upd_count,
    input  logic [AW-1:0] list_addr,
    output logic [CW-1:0] list_idx,
    output logic          shift_en,
    output logic          sbit,
    output logic          wr_en,
    output logic          idle,
    output logic          busy,
    output logic          done
);
    localparam logic [AW-1:0] LAST_BIT = AW'(AW - 1);

    ras_state_e    state_q, state_d;
    logic [AW-1:0] bcnt_q, bcnt_d;
    logic [CW-1:0] idx_q, idx_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [AW-1:0] addr_sh;

    always_comb begin
        state_d = state_q;
        bcnt_d  = bcnt_q;
        idx_d   = idx_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RS_IDLE: begin
                if (start) begin
                    cnt_d   = upd_count;
                    idx_d   = '0;
                    bcnt_d  = '0;
                    state_d = (upd_count == '0) ? RS_FINISH : RS_SHIFT;
                end
            end
            RS_SHIFT: begin
                if (bcnt_q == LAST_BIT) begin
                    bcnt_d  = '0;
                    state_d = RS_WRITE;
                end else begin
                    bcnt_d = bcnt_q + 1'b1;
                end
            end
            RS_WRITE: begin
                if (idx_q == cnt_q - 1'b1) begin
                    state_d = RS_FINISH;
                end else begin
                    idx_d   = idx_q + 1'b1;
                    state_d = RS_SHIFT;
                end
            end
            RS_FINISH: state_d = RS_IDLE;
            default:   state_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            bcnt_q  <= '0;
            idx_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            bcnt_q  <= bcnt_d;
            idx_q   <= idx_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        addr_sh  = list_addr << bcnt_q;
        list_idx = idx_q;
        sbit     = (state_q == RS_SHIFT) ? addr_sh[AW-1] : 1'b0;
        shift_en = (state_q == RS_SHIFT);
        wr_en    = (state_q == RS_WRITE);
        idle     = (state_q == RS_IDLE);
        busy     = (state_q == RS_SHIFT) || (state_q == RS_WRITE);
        done     = (state_q == RS_FINISH);
    end
endmodule

// File: rtl/ras_addr_shifter.sv
module ras_addr_shifter #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic          sbit,
    output logic [AW-1:0] addr
);
    generate
        if (AW == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        addr <= '0;
                else if (shift_en) addr <= sbit;
            end
        end else begin : g_wide
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        addr <= '0;
                else if (shift_en) addr <= {addr[AW-2:0], sbit};
            end
        end
    endgenerate
endmodule

// File: rtl/ras_cell_array.sv
module ras_cell_array #(
    parameter int NCELLS = 12,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              wr_en,
    input  logic              wr_val,
    input  logic              cap_go,
    input  logic [NCELLS-1:0] cap_data,
    output logic [NCELLS-1:0] cells
);
    generate
        for (genvar i = 0; i < NCELLS; i++) begin : g_cell
            logic hit;
            assign hit = wr_en && (addr == AW'(i));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      cells[i] <= 1'b0;
                else if (cap_go) cells[i] <= cap_data[i];
                else if (hit)    cells[i] <= wr_val;
            end
        end
    endgenerate
endmodule

// File: rtl/ras_update_ctrl.sv
module ras_update_ctrl #(
    parameter int NCELLS = 12,
    localparam int AW = (NCELLS > 1) ? $clog2(NCELLS) : 1,
    localparam int CW = $clog2(NCELLS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CW-1:0]     upd_count,
    output logic [CW-1:0]     list_idx,
    input  logic [AW-1:0]     list_addr,
    input  logic              list_val,
    input  logic              cap_en,
    input  logic [NCELLS-1:0] cap_data,
    output logic [NCELLS-1:0] cells,
    output logic              addr_sbit,
    output logic              busy,
    output logic              done
);
    logic          shift_en;
    logic          wr_en;
    logic          idle;
    logic [AW-1:0] cell_addr;

    ras_seq #(.AW(AW), .CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .upd_count(upd_count),
        .list_addr(list_addr), .list_idx(list_idx), .shift_en(shift_en),
        .sbit(addr_sbit), .wr_en(wr_en), .idle(idle), .busy(busy), .done(done)
    );

    ras_addr_shifter #(.AW(AW)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .sbit(addr_sbit),
        .addr(cell_addr)
    );

    ras_cell_array #(.NCELLS(NCELLS), .AW(AW)) u_array (
        .clk(clk), .rst_n(rst_n), .addr(cell_addr), .wr_en(wr_en),
        .wr_val(list_val), .cap_go(cap_en && idle), .cap_data(cap_data),
        .cells(cells)
    );
endmodule

// File: rtl/ras_update_ctrl_chk.sv
module ras_update_ctrl_chk #(
    parameter int NCELLS = 12,
    parameter int AW = 4,
    parameter int CW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [CW-1:0]     upd_count,
    input logic              cap_en,
    input logic [NCELLS-1:0] cells,
    input logic              wr_en,
    input logic              busy,
    input logic              done
);
    logic [31:0] busy_cnt;
    logic [31:0] d_lat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
            d_lat    <= '0;
        end else if (start && !busy && !done) begin
            busy_cnt <= '0;
            d_lat    <= 32'(upd_count);
        end else if (busy) begin
            busy_cnt <= busy_cnt + 1;
        end
    end

    // R6: done lasts one cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6: the end of a run is followed by done
    a_r6_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R3: busy cycles in a run equal d*(1+T)
    a_r3_run_length: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy_cnt == d_lat * (AW + 1));
    // R4: cells hold outside writes and accepted captures
    a_r4_cells_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !(cap_en && !busy && !done)) |=> $stable(cells));
    // R4: at most one cell changes per cycle during a run
    a_r4_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $countones(cells ^ $past(cells)) <= 1);
endmodule

bind ras_update_ctrl ras_update_ctrl_chk #(.NCELLS(NCELLS), .AW(AW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .upd_count(upd_count),
    .cap_en(cap_en), .cells(cells), .wr_en(wr_en), .busy(busy), .done(done)
);

// File: tb/sim_ras_update_ctrl.sv
`timescale 1ns/1ps
module sim_ras_update_ctrl;
    localparam int N  = 12;
    localparam int AW = 4;
    localparam int CW = 4;
    localparam int M  = 3;
    localparam int LCHAIN = (N + M - 1) / M;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          start = 0;
    logic [CW-1:0] upd_count = '0;
    logic [CW-1:0] list_idx;
    logic [AW-1:0] list_addr;
    logic          list_val;
    logic          cap_en = 0;
    logic [N-1:0]  cap_data = '0;
    logic [N-1:0]  cells;
    logic          addr_sbit, busy, done;

    logic [AW-1:0] lst_a [16];
    logic          lst_v [16];
    logic [N-1:0]  model;
    int checks = 0, failures = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    assign list_addr = lst_a[list_idx];
    assign list_val  = lst_v[list_idx];

    ras_update_ctrl #(.NCELLS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .upd_count(upd_count),
        .list_idx(list_idx), .list_addr(list_addr), .list_val(list_val),
        .cap_en(cap_en), .cap_data(cap_data), .cells(cells),
        .addr_sbit(addr_sbit), .busy(busy), .done(done)
    );

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [15:0] nxt(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    // Applies list of d entries; mid-run stimuli optional
    task automatic run(input int d, input logic poke);
        int c, sbad;
        int e, k;
        logic [AW-1:0] a;
        logic saw_done;
        c = 0; sbad = 0; saw_done = 0;
        upd_count = CW'(d);
        start = 1;
        step();
        start = 0;
        for (int g = 0; g < 2000 && !saw_done; g++) begin
            if (busy) begin
                e = c / (AW + 1);
                k = c % (AW + 1);
                if (k < AW) begin
                    a = lst_a[e];
                    if (addr_sbit !== a[AW-1-k]) sbad++;
                end
                if (list_idx !== CW'(e)) sbad++;
                if (poke && c == 2) begin
                    start = 1; upd_count = CW'(1);
                    cap_en = 1; cap_data = ~model;
                end
                c++;
            end
            if (done) saw_done = 1;
            else step();
            start = 0; cap_en = 0;
        end
        chk(saw_done, "R6 done reached (watchdog)", saw_done, 1);
        chk(c == d * (AW + 1), "R3 busy cycle count", c, d * (AW + 1));
        chk(sbad == 0, "R3/R8 serial MSB-first address and entry order", sbad, 0);
        for (int i = 0; i < d; i++)
            if (lst_a[i] < N) model[lst_a[i]] = lst_v[i];
        chk(cells === model, "R4/R5/R8 array contents", cells, model);
        start = 1; upd_count = CW'(1); cap_en = 1; cap_data = ~model;
        step();
        start = 0; cap_en = 0;
        chk(!done, "R6 done single cycle", done, 0);
        chk(!busy && cells === model, "R7/R2 start and capture ignored while done",
            {busy, cells}, {1'b0, model});
        step();
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin lst_a[i] = '0; lst_v[i] = 0; end
        #1;
        chk(cells === '0 && !busy && !done, "R1 reset state", {busy, done, cells}, 0);
        step(); rst_n = 1; step();
        chk(cells === '0 && !busy && !done, "R1 state after reset release", {busy, done, cells}, 0);

        model = 12'hA5C;
        cap_data = model; cap_en = 1; step(); cap_en = 0;
        chk(cells === model, "R2 capture while idle", cells, model);

        // d = 0
        upd_count = '0; start = 1; step(); start = 0;
        chk(!busy && done, "R6 zero-length list gives done, no busy", {busy, done}, 1);
        step();
        chk(!done && cells === model, "R6 zero-length done single", {done, cells}, model);

        // Exhaustive single entries over every address code, both values
        for (int a = 0; a < 16; a++) begin
            for (int v = 0; v < 2; v++) begin
                lst_a[0] = AW'(a); lst_v[0] = v[0];
                run(1, 0);
            end
        end

        // Multi-entry pseudo-random lists with duplicates and invalid addresses
        for (int t = 0; t < 24; t++) begin
            int d;
            lfsr = nxt(lfsr);
            d = 1 + (lfsr % 12);
            for (int i = 0; i < d; i++) begin
                lfsr = nxt(lfsr);
                lst_a[i] = lfsr[3:0];
                lst_v[i] = lfsr[7];
            end
            run(d, t[0]);
            $display("vector %0d: d=%0d random-access cycles=%0d full-scan cycles=%0d",
                     t, d, d * (AW + 1), LCHAIN);
        end

        // Same cell written twice: later entry wins (R8)
        lst_a[0] = 4'd3; lst_v[0] = 1; lst_a[1] = 4'd3; lst_v[1] = 0;
        run(2, 1);
        chk(cells[3] === 1'b0, "R8 later duplicate wins", cells[3], 0);

        // Full list, all cells set
        for (int i = 0; i < N; i++) begin lst_a[i] = AW'(i); lst_v[i] = 1; end
        run(N, 0);
        chk(cells === '1, "R4 all cells set by full list", cells, 12'hFFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule